// File: doc/BRIEF.md
# Jump Resolver with Rollback Issue

This block sits in the execution pipe of a multithreaded core and decides, for each jump instruction that reaches it, whether the jump is taken and where it goes. Each cycle it may accept one instruction. The instruction arrives with these fields:

- a jump kind
- the issuing thread number
- the instruction's PC
- lane 0 of operand 0, which holds either a condition value or a base address
- lane 0 of operand 1, which holds an immediate offset
- the thread's scoreboard snapshot

A taken jump produces a registered rollback request one cycle later. The request carries the thread number, the target PC and the scoreboard that the rollback handler must restore. A jump that is not taken produces no request, and the thread continues sequentially.

There are two instruction formats. A relative jump is always taken to PC plus the sign-extended immediate. A register-based jump takes one of three forms:

- conditional on the register being zero, to PC plus immediate
- conditional on the register being non-zero, to PC plus immediate
- unconditional, to the address held in the register

The output stage is a two-state machine. RB_IDLE means no request is presented. RB_ISSUE means a request is presented for this cycle. The transitions are:

- ENTER: RB_IDLE to RB_ISSUE, taken when a taken jump is sampled.
- REPEAT: RB_ISSUE to RB_ISSUE, taken when another taken jump is sampled back to back.
- RETIRE: RB_ISSUE to RB_IDLE, taken when no taken jump is sampled.
- STAY: RB_IDLE to RB_IDLE, taken when no taken jump is sampled.

Top module: `jump_resolver`

## Requirements
- R1: After reset `rb_valid` is 0 and `rb_thread`, `rb_pc` and `rb_scoreboard` are all zero.
- R2: A valid jump with `in_kind` = 2'b00 (relative) is always taken, whatever `in_op0` holds. Its target is `in_pc` plus `in_op1[IMM_W-1:0]` sign-extended to ADDR_W bits, modulo 2^ADDR_W.
- R3: A valid jump with `in_kind` = 2'b01 (register equal to zero) is taken exactly when all REG_W bits of `in_op0` are zero. Its target is as in R2.
- R4: A valid jump with `in_kind` = 2'b10 (register not zero) is taken exactly when `in_op0` is non-zero. Its target is as in R2.
- R5: A valid jump with `in_kind` = 2'b11 (absolute) is always taken, whatever `in_op1` holds. Its target is the low ADDR_W bits of `in_op0`, zero-extended if ADDR_W exceeds REG_W.
- R6: A rollback request carries the `in_thread` and `in_scoreboard` values that came with the taken jump.
- R7: A taken jump sampled at a rising edge raises `rb_valid` for exactly the following cycle. Taken jumps on consecutive cycles give consecutive requests, each carrying its own payload.
- R8: When `in_valid` is 0 at an edge, `rb_valid` is 0 in the following cycle, whatever the other inputs hold.
- R9: After a cycle with no taken jump, `rb_thread`, `rb_pc` and `rb_scoreboard` keep the values of the last request.
- R10: Bits of `in_op1` above IMM_W-1 have no effect on the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A jump instruction is present this cycle |
| in_kind | input | 2 | Jump kind: 00 relative, 01 equal zero, 10 not zero, 11 absolute |
| in_thread | input | TID_W | Issuing thread number |
| in_pc | input | ADDR_W | PC of the jump instruction |
| in_op0 | input | REG_W | Operand 0 lane 0: condition value or base address |
| in_op1 | input | REG_W | Operand 1 lane 0: immediate in the low IMM_W bits |
| in_scoreboard | input | SB_W | Scoreboard snapshot of the issuing thread |
| rb_valid | output | 1 | Rollback request present |
| rb_thread | output | TID_W | Thread to roll back |
| rb_pc | output | ADDR_W | PC to restart that thread from |
| rb_scoreboard | output | SB_W | Scoreboard to restore |

## Verification
A fault in the decision logic or the state register appears at `rb_valid` exactly one cycle after the offending instruction. It shows as a missing request, an extra request, or a request that lingers into a second cycle. A fault in the target datapath shows in `rb_pc` in that same cycle. Faults of this kind include a lost sign extension, leaked upper immediate bits, or a swapped base and relative path. A payload register that updates when it should hold is visible on the first not-taken cycle afterwards, because the payload no longer matches the last request.

// File: rtl/jump_resolver_pkg.sv
package jump_resolver_pkg;

    // Jump kind encoding seen at in_kind
    typedef enum logic [1:0] {
        JMP_REL = 2'b00,
        JMP_EQZ = 2'b01,
        JMP_NEZ = 2'b10,
        JMP_ABS = 2'b11
    } jump_kind_e;

    // Output stage states
    typedef enum logic {
        RB_IDLE  = 1'b0,
        RB_ISSUE = 1'b1
    } rb_state_e;

endpackage

// File: rtl/jump_cond_eval.sv
module jump_cond_eval
    import jump_resolver_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  jump_kind_e       kind,
    input  logic [REG_W-1:0] op0,
    output logic             taken,
    output logic             use_base
);

    logic op0_zero;

    assign op0_zero = (op0 == '0);

    always_comb begin
        unique case (kind)
            JMP_REL: begin
                taken    = 1'b1;
                use_base = 1'b0;
            end
            JMP_EQZ: begin
                taken    = op0_zero;
                use_base = 1'b0;
            end
            JMP_NEZ: begin
                taken    = !op0_zero;
                use_base = 1'b0;
            end
            JMP_ABS: begin
                taken    = 1'b1;
                use_base = 1'b1;
            end
            default: begin
                taken    = 1'b0;
                use_base = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/jump_target_calc.sv
module jump_target_calc #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int IMM_W  = 18
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [REG_W-1:0]  op0,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_base,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] rel_addr;

    // Signed cast widens with sign extension, or truncates when narrower
    assign imm_ext   = ADDR_W'($signed(imm));
    assign base_addr = ADDR_W'(op0);
    assign rel_addr  = pc + imm_ext;
    assign target    = use_base ? base_addr : rel_addr;

endmodule

// File: rtl/rollback_issue.sv
module rollback_issue
    import jump_resolver_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TID_W  = 3,
    parameter int SB_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [TID_W-1:0]  fire_thread,
    input  logic [ADDR_W-1:0] fire_target,
    input  logic [SB_W-1:0]   fire_sb,
    output logic              rb_valid,
    output logic [TID_W-1:0]  rb_thread,
    output logic [ADDR_W-1:0] rb_pc,
    output logic [SB_W-1:0]   rb_scoreboard
);

    rb_state_e state_q, state_d;

    // Next-state selection: ENTER, REPEAT, RETIRE, STAY
    always_comb begin
        unique case (state_q)
            RB_IDLE:  state_d = fire ? RB_ISSUE : RB_IDLE;
            RB_ISSUE: state_d = fire ? RB_ISSUE : RB_IDLE;
            default:  state_d = RB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload registers: load only on a taken jump, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_thread     <= '0;
            rb_pc         <= '0;
            rb_scoreboard <= '0;
        end else if (fire) begin
            rb_thread     <= fire_thread;
            rb_pc         <= fire_target;
            rb_scoreboard <= fire_sb;
        end
    end

    // Output decode from state
    always_comb begin
        unique case (state_q)
            RB_ISSUE: rb_valid = 1'b1;
            default:  rb_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
    import jump_resolver_pkg::*;
#(
    parameter int THREADS = 8,
    parameter int ADDR_W  = 32,
    parameter int REG_W   = 32,
    parameter int IMM_W   = 18,
    parameter int SB_W    = 64,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [TID_W-1:0]  in_thread,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [REG_W-1:0]  in_op0,
    input  logic [REG_W-1:0]  in_op1,
    input  logic [SB_W-1:0]   in_scoreboard,
    output logic              rb_valid,
    output logic [TID_W-1:0]  rb_thread,
    output logic [ADDR_W-1:0] rb_pc,
    output logic [SB_W-1:0]   rb_scoreboard
);

    jump_kind_e        kind;
    logic              cond_taken;
    logic              use_base;
    logic              fire;
    logic [ADDR_W-1:0] target;

    assign kind = jump_kind_e'(in_kind);
    assign fire = in_valid && cond_taken;

    jump_cond_eval #(
        .REG_W (REG_W)
    ) u_cond (
        .kind     (kind),
        .op0      (in_op0),
        .taken    (cond_taken),
        .use_base (use_base)
    );

    jump_target_calc #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .IMM_W  (IMM_W)
    ) u_target (
        .pc       (in_pc),
        .op0      (in_op0),
        .imm      (in_op1[IMM_W-1:0]),
        .use_base (use_base),
        .target   (target)
    );

    rollback_issue #(
        .ADDR_W (ADDR_W),
        .TID_W  (TID_W),
        .SB_W   (SB_W)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .fire_thread   (in_thread),
        .fire_target   (target),
        .fire_sb       (in_scoreboard),
        .rb_valid      (rb_valid),
        .rb_thread     (rb_thread),
        .rb_pc         (rb_pc),
        .rb_scoreboard (rb_scoreboard)
    );

endmodule

// File: rtl/jump_resolver_chk.sv
module jump_resolver_chk #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int IMM_W  = 18,
    parameter int SB_W   = 64,
    parameter int TID_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_kind,
    input logic [TID_W-1:0]  in_thread,
    input logic [ADDR_W-1:0] in_pc,
    input logic [REG_W-1:0]  in_op0,
    input logic [REG_W-1:0]  in_op1,
    input logic [SB_W-1:0]   in_scoreboard,
    input logic              rb_valid,
    input logic [TID_W-1:0]  rb_thread,
    input logic [ADDR_W-1:0] rb_pc,
    input logic [SB_W-1:0]   rb_scoreboard
);

    logic [ADDR_W-1:0] chk_base;
    logic              chk_zero;

    assign chk_base = ADDR_W'(in_op0);
    assign chk_zero = (in_op0 == '0);

    p_rel_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b00) |=> rb_valid);

    p_eqz_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01) |=> (rb_valid == $past(chk_zero)));

    p_nez_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b10) |=> (rb_valid == !$past(chk_zero)));

    p_abs_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11) |=> (rb_valid && rb_pc == $past(chk_base)));

    p_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_kind == 2'b00 || in_kind == 2'b11)) |=>
            (rb_thread == $past(in_thread) && rb_scoreboard == $past(in_scoreboard)));

    p_no_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !rb_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(rb_pc) && $stable(rb_thread) && $stable(rb_scoreboard)));

    // R1: reset values, checked while reset is applied at an edge
    always @(posedge clk) begin
        if (!rst_n) begin
            #1;
            p_reset_r1: assert (!rb_valid && rb_pc == '0);
        end
    end

endmodule

bind jump_resolver jump_resolver_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .IMM_W  (IMM_W),
    .SB_W   (SB_W),
    .TID_W  (TID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_kind       (in_kind),
    .in_thread     (in_thread),
    .in_pc         (in_pc),
    .in_op0        (in_op0),
    .in_op1        (in_op1),
    .in_scoreboard (in_scoreboard),
    .rb_valid      (rb_valid),
    .rb_thread     (rb_thread),
    .rb_pc         (rb_pc),
    .rb_scoreboard (rb_scoreboard)
);

// File: tb/sim_jump_resolver.sv
`timescale 1ns/1ps
module sim_jump_resolver;

    localparam int THREADS = 4;
    localparam int ADDR_W  = 8;
    localparam int REG_W   = 8;
    localparam int IMM_W   = 4;
    localparam int SB_W    = 8;
    localparam int TID_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [TID_W-1:0]  in_thread = '0;
    logic [ADDR_W-1:0] in_pc = '0;
    logic [REG_W-1:0]  in_op0 = '0;
    logic [REG_W-1:0]  in_op1 = '0;
    logic [SB_W-1:0]   in_scoreboard = '0;
    logic              rb_valid;
    logic [TID_W-1:0]  rb_thread;
    logic [ADDR_W-1:0] rb_pc;
    logic [SB_W-1:0]   rb_scoreboard;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state
    bit   m_valid;
    int   m_thread;
    int   m_pc;
    int   m_sb;

    always #4 clk = ~clk;

    jump_resolver #(
        .THREADS (THREADS),
        .ADDR_W  (ADDR_W),
        .REG_W   (REG_W),
        .IMM_W   (IMM_W),
        .SB_W    (SB_W)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_kind       (in_kind),
        .in_thread     (in_thread),
        .in_pc         (in_pc),
        .in_op0        (in_op0),
        .in_op1        (in_op1),
        .in_scoreboard (in_scoreboard),
        .rb_valid      (rb_valid),
        .rb_thread     (rb_thread),
        .rb_pc         (rb_pc),
        .rb_scoreboard (rb_scoreboard)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one instruction on a falling edge, step one clock, compare with the model
    task automatic step(input bit v, input int k, input int thr, input int pc,
                        input int op0, input int op1, input int sb);
        bit taken;
        int simm;
        int tgt;
        string req;
        in_valid      = v;
        in_kind       = 2'(k);
        in_thread     = TID_W'(thr);
        in_pc         = ADDR_W'(pc);
        in_op0        = REG_W'(op0);
        in_op1        = REG_W'(op1);
        in_scoreboard = SB_W'(sb);
        simm = op1 & 15;
        if (simm >= 8) simm = simm - 16;
        case (k)
            0: begin taken = 1'b1;                  tgt = (pc + simm) & 255; req = "R2"; end
            1: begin taken = ((op0 & 255) == 0);    tgt = (pc + simm) & 255; req = "R3"; end
            2: begin taken = ((op0 & 255) != 0);    tgt = (pc + simm) & 255; req = "R4"; end
            default: begin taken = 1'b1;            tgt = op0 & 255;         req = "R5"; end
        endcase
        if (!v) begin
            taken = 1'b0;
            req = "R8";
        end
        m_valid = taken;
        if (taken) begin
            m_thread = thr & 3;
            m_pc     = tgt;
            m_sb     = sb & 255;
        end
        @(negedge clk);
        check(rb_valid == m_valid, v ? req : "R8", int'(rb_valid), int'(m_valid));
        if (taken) begin
            check(int'(rb_pc) == m_pc, req, int'(rb_pc), m_pc);
            check(int'(rb_thread) == m_thread && int'(rb_scoreboard) == m_sb, "R6",
                  int'(rb_scoreboard), m_sb);
        end else begin
            check(int'(rb_pc) == m_pc && int'(rb_thread) == m_thread &&
                  int'(rb_scoreboard) == m_sb, "R9", int'(rb_pc), m_pc);
        end
    endtask

    initial begin
        m_valid = 1'b0; m_thread = 0; m_pc = 0; m_sb = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rb_valid, "R1", int'(rb_valid), 0);
        check(rb_pc == '0 && rb_thread == '0 && rb_scoreboard == '0, "R1", int'(rb_pc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rb_valid, "R1", int'(rb_valid), 0);

        // Sweep all kinds, all immediates, several operand and PC patterns.
        // Upper op1 bits are varied to exercise R10 in every relative target.
        for (int k = 0; k < 4; k++) begin
            for (int imm = 0; imm < 16; imm++) begin
                for (int oi = 0; oi < 5; oi++) begin
                    for (int pi = 0; pi < 3; pi++) begin
                        int op0v;
                        int pcv;
                        int n;
                        op0v = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 128 : (oi == 3) ? 255 : 16;
                        pcv  = (pi == 0) ? 0 : (pi == 1) ? 127 : 248;
                        n    = k * 240 + imm * 15 + oi * 3 + pi;
                        step(1'b1, k, n, pcv, op0v, ((n * 7) << 4) | imm, n * 13);
                        // R8/R9: an invalid slot with opposite-looking operands every third step
                        if ((n % 3) == 0) step(1'b0, 3 - k, n + 1, 255 - pcv, 0, 15, 255 - n);
                    end
                end
            end
        end

        // R7: single request lasts one cycle, back-to-back requests stay up
        step(1'b1, 0, 1, 16, 0, 3, 5);
        step(1'b1, 3, 2, 0, 77, 0, 6);
        check(int'(rb_pc) == 77 && rb_valid, "R7", int'(rb_pc), 77);
        step(1'b1, 1, 3, 10, 9, 2, 7);
        check(!rb_valid, "R7", int'(rb_valid), 0);

        // R10: upper immediate bits do not change the target
        step(1'b1, 0, 0, 100, 0, 8'h05, 1);
        check(int'(rb_pc) == 105, "R10", int'(rb_pc), 105);
        step(1'b1, 0, 0, 100, 0, 8'hF5, 1);
        check(int'(rb_pc) == 105, "R10", int'(rb_pc), 105);
        step(1'b1, 2, 0, 100, 4, 8'h7C, 1);
        check(int'(rb_pc) == 96, "R10", int'(rb_pc), 96);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule